// File: doc/BRIEF.md
# Keyboard Matrix Scan Port

This block connects a 12-row by 7-column keyboard matrix and a cassette input bit to a CPU read window. The CPU scans the keyboard by reading from the window. The low eleven address bits of that read choose which row lines are pulled low. Each key shorts its row to its column, and the columns are pulled high. The column levels, together with the tape input level, come back as one byte.

The address bits select rows in two ways. The eight lowest bits each drive one row directly, active low. Three higher bits form a binary code, and that code picks one of four further rows. Codes 4 to 7 pick no further row. The block responds only when the I/O bank select is asserted and the address falls in the 2 KiB window at 0x6800–0x6FFF. Any other read leaves every row released and the bus undriven.

The row lines follow the address combinationally during the read cycle. The column and tape levels are sampled at the clock edge that ends that cycle. The byte appears in the next cycle, marked by `rd_valid`. This output has no ready input and gives no back-pressure. The byte is held for exactly one cycle and then drops to zero. The consumer must take it in that cycle.

Top module: `kbd_matrix_reader`

## Requirements
- R1: While no decoded read is in progress, including during reset, all 12 row lines stay high (released).
- R2: During a decoded read, row r (0–7) is driven low exactly when address bit r is 0. For example, 0x6FFE selects row 0 and 0x6F7F selects row 7.
- R3: During a decoded read, the 3-bit value v in address bits 10:8 drives row 8+v low for v = 0 to 3. Values 4 to 7 drive none of rows 8–11.
- R4: A read is decoded only when `cpu_rd` is 1, `io_bank_sel` is 1 and address bits 15:11 equal 5'b01101 (0x6800–0x6FFF). Any other cycle leaves all rows high and gives `rd_valid` = 0 in the following cycle.
- R5: In the cycle after a decoded read, `rd_valid` is 1. `rd_data[6:0]` then holds the column levels (column c in bit c, 0 = pressed), and `rd_data[7]` holds the tape level, both sampled at the clock edge that ended the read.
- R6: If several rows are selected at once, all of them are driven low. Each returned column bit is then the AND of that column over all the selected rows.
- R7: If no key is pressed on the selected rows, `rd_data[6:0]` reads 0x7F.
- R8: Whenever `rd_valid` is 0, including after reset, `rd_data` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU address of the current cycle |
| cpu_rd | input | 1 | Read strobe, one cycle per read |
| io_bank_sel | input | 1 | High when the I/O bank is mapped |
| col_sense_n | input | 7 | Column lines from the matrix, pulled high, 0 = pressed |
| tape_in | input | 1 | Cassette input level |
| row_drive_n | output | 12 | Row lines, 0 = row selected |
| rd_data | output | 8 | Returned byte: tape level in bit 7, columns in bits 6:0 |
| rd_valid | output | 1 | Marks the single cycle in which rd_data is driven |

## Verification
Direct row selection and coded row selection can be active in the same read. For example, 0x68FC pulls down rows 0 and 1 through the direct bits and row 8 through code 0. The bench provokes this by pressing keys on each of those rows in different columns, so the returned byte is only right if all three rows are ANDed. A behavioural model of the matrix and the port computes the expected row lines and the expected byte every clock and compares them with the outputs. Reads with code values 4–7 are also combined with direct bits, to show that coded selection adds no row in those cases.

// File: rtl/kbd_pkg.sv
package kbd_pkg;
  localparam int KBD_ADDR_W      = 16;
  localparam int KBD_DIRECT_ROWS = 8;
  localparam int KBD_CODE_W      = 3;
  localparam int KBD_CODED_ROWS  = 4;
  localparam int KBD_COLS        = 7;
  localparam int KBD_WIN_TAG     = 13; // 0x6800 >> 11

  function automatic int kbd_rows(input int direct_rows, input int coded_rows);
    return direct_rows + coded_rows;
  endfunction
endpackage

// File: rtl/kbd_window_dec.sv
module kbd_window_dec #(
  parameter int ADDR_W  = 16,
  parameter int SEL_W   = 11,
  parameter int WIN_TAG = 13
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_i,
  input  logic              bank_i,
  output logic              hit_o,
  output logic [SEL_W-1:0]  sel_o
);
  localparam int TAG_W = ADDR_W - SEL_W;

  logic tag_match;
  assign tag_match = (addr_i[ADDR_W-1:SEL_W] == TAG_W'(WIN_TAG));
  assign hit_o     = rd_i & bank_i & tag_match;
  assign sel_o     = addr_i[SEL_W-1:0];
endmodule

// File: rtl/kbd_row_drv.sv
module kbd_row_drv #(
  parameter int DIRECT_ROWS = 8,
  parameter int CODE_W      = 3,
  parameter int CODED_ROWS  = 4
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 hit_i,
  input  logic [DIRECT_ROWS+CODE_W-1:0]        sel_i,
  output logic [DIRECT_ROWS+CODED_ROWS-1:0]    row_n_o
);
  localparam int SEL_W = DIRECT_ROWS + CODE_W;
  localparam int ROWS  = DIRECT_ROWS + CODED_ROWS;

  logic [CODE_W-1:0] code;
  assign code = sel_i[SEL_W-1:DIRECT_ROWS];

  // direct rows: one active-low address bit per row
  for (genvar i = 0; i < DIRECT_ROWS; i++) begin : g_direct
    assign row_n_o[i] = ~(hit_i & ~sel_i[i]);
  end

  // coded rows: binary decode, unused codes select nothing
  for (genvar j = 0; j < CODED_ROWS; j++) begin : g_coded
    assign row_n_o[DIRECT_ROWS+j] = ~(hit_i && (code == CODE_W'(j)));
  end

  // R1: no decoded read, no row pulled low
  a_r1_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_i |-> &row_n_o);

  // R3: at most one coded row is ever active
  a_r3_coded_onehot0: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~row_n_o[ROWS-1:DIRECT_ROWS]));

  // R3: codes at or above the coded row count select no coded row
  a_r3_high_code_none: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(code) >= CODED_ROWS) |-> &row_n_o[ROWS-1:DIRECT_ROWS]);
endmodule

// File: rtl/kbd_capture.sv
module kbd_capture #(
  parameter int COLS = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hit_i,
  input  logic [COLS-1:0] col_n_i,
  input  logic          tape_i,
  output logic [COLS:0] data_o,
  output logic          valid_o
);
  logic [COLS:0] data_q;
  logic          valid_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= hit_i;
      data_q  <= hit_i ? {tape_i, col_n_i} : '0;
    end
  end

  assign data_o  = data_q;
  assign valid_o = valid_q;

  // R5: a decoded read returns the levels seen at its closing edge
  a_r5_capture: assert property (@(posedge clk) disable iff (!rst_n)
    hit_i |=> (valid_o && data_o == $past({tape_i, col_n_i})));
endmodule

// File: rtl/kbd_matrix_reader.sv
module kbd_matrix_reader
  import kbd_pkg::*;
#(
  parameter int ADDR_W      = KBD_ADDR_W,
  parameter int DIRECT_ROWS = KBD_DIRECT_ROWS,
  parameter int CODE_W      = KBD_CODE_W,
  parameter int CODED_ROWS  = KBD_CODED_ROWS,
  parameter int COLS        = KBD_COLS,
  parameter int WIN_TAG     = KBD_WIN_TAG,
  localparam int SEL_W      = DIRECT_ROWS + CODE_W,
  localparam int ROWS       = kbd_rows(DIRECT_ROWS, CODED_ROWS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_rd,
  input  logic              io_bank_sel,
  input  logic [COLS-1:0]   col_sense_n,
  input  logic              tape_in,
  output logic [ROWS-1:0]   row_drive_n,
  output logic [COLS:0]     rd_data,
  output logic              rd_valid
);
  logic             hit;
  logic [SEL_W-1:0] sel;

  kbd_window_dec #(.ADDR_W(ADDR_W), .SEL_W(SEL_W), .WIN_TAG(WIN_TAG)) u_win (
    .addr_i (cpu_addr),
    .rd_i   (cpu_rd),
    .bank_i (io_bank_sel),
    .hit_o  (hit),
    .sel_o  (sel)
  );

  kbd_row_drv #(.DIRECT_ROWS(DIRECT_ROWS), .CODE_W(CODE_W), .CODED_ROWS(CODED_ROWS)) u_rows (
    .clk     (clk),
    .rst_n   (rst_n),
    .hit_i   (hit),
    .sel_i   (sel),
    .row_n_o (row_drive_n)
  );

  kbd_capture #(.COLS(COLS)) u_cap (
    .clk     (clk),
    .rst_n   (rst_n),
    .hit_i   (hit),
    .col_n_i (col_sense_n),
    .tape_i  (tape_in),
    .data_o  (rd_data),
    .valid_o (rd_valid)
  );

  // R4: without strobe and bank select, rows stay released
  a_r4_no_rows_unmapped: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_rd || !io_bank_sel) |-> &row_drive_n);

  // R4: a cycle that is not a read gives no valid byte next cycle
  a_r4_no_valid_unread: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_rd |=> !rd_valid);

  // R8: bus quiet outside the valid cycle
  a_r8_quiet_bus: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |-> (rd_data == '0));
endmodule

// File: tb/kbd_matrix_reader_tb.sv
module kbd_matrix_reader_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = 16'h0;
  logic        cpu_rd = 1'b0;
  logic        io_bank_sel = 1'b0;
  logic [6:0]  col_sense_n;
  logic        tape_in = 1'b0;
  logic [11:0] row_drive_n;
  logic [7:0]  rd_data;
  logic        rd_valid;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  string cur_req = "R1";

  logic [11:0][6:0] keys = '0; // 1 = pressed

  always #10 clk = ~clk; // 50 MHz

  kbd_matrix_reader dut_i (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd),
    .io_bank_sel(io_bank_sel), .col_sense_n(col_sense_n), .tape_in(tape_in),
    .row_drive_n(row_drive_n), .rd_data(rd_data), .rd_valid(rd_valid)
  );

  // physical matrix: a pressed key on a low row pulls its column low
  always_comb begin
    col_sense_n = 7'h7F;
    for (int r = 0; r < 12; r++)
      for (int c = 0; c < 7; c++)
        if (!row_drive_n[r] && keys[r][c]) col_sense_n[c] = 1'b0;
  end

  // reference model
  function automatic bit m_hit(input logic [15:0] a, input logic rd, input logic bk);
    return rd && bk && (a >= 16'h6800) && (a <= 16'h6FFF);
  endfunction

  function automatic logic [11:0] m_rows(input logic [15:0] a, input logic rd, input logic bk);
    logic [11:0] rows = 12'hFFF;
    int code = (a >> 8) & 7;
    if (m_hit(a, rd, bk)) begin
      for (int r = 0; r < 8; r++) if (a[r] == 1'b0) rows[r] = 1'b0;
      if (code < 4) rows[8 + code] = 1'b0;
    end
    return rows;
  endfunction

  function automatic logic [6:0] m_cols(input logic [11:0] rows);
    logic [6:0] v = 7'h7F;
    for (int r = 0; r < 12; r++)
      for (int c = 0; c < 7; c++)
        if (!rows[r] && keys[r][c]) v[c] = 1'b0;
    return v;
  endfunction

  logic       exp_valid;
  logic [7:0] exp_data;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_valid <= 1'b0;
      exp_data  <= 8'h00;
    end else if (m_hit(cpu_addr, cpu_rd, io_bank_sel)) begin
      exp_valid <= 1'b1;
      exp_data  <= {tape_in, m_cols(m_rows(cpu_addr, cpu_rd, io_bank_sel))};
    end else begin
      exp_valid <= 1'b0;
      exp_data  <= 8'h00;
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      check(cur_req, "rows", row_drive_n, m_rows(cpu_addr, cpu_rd, io_bank_sel));
      check(cur_req, "valid", rd_valid, exp_valid);
      check(cur_req, "data", rd_data, exp_data);
    end
  end

  // one read cycle, then an idle cycle; returns byte seen in the valid cycle
  task automatic do_read(input logic [15:0] a, input logic bk, input logic rd,
                         output logic [7:0] got, output logic v);
    @(posedge clk); #2;
    cpu_addr = a; io_bank_sel = bk; cpu_rd = rd;
    @(posedge clk); #2;
    cpu_rd = 1'b0; io_bank_sel = 1'b0;
    @(negedge clk);
    got = rd_data; v = rd_valid;
  endtask

  task automatic finish_run();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] got;
    logic v;
    // reset state: R1, R8
    cur_req = "R8";
    repeat (3) @(negedge clk);
    check("R8", "reset valid", rd_valid, 0);
    check("R8", "reset data", rd_data, 0);
    check("R1", "reset rows", row_drive_n, 12'hFFF);
    @(posedge clk); #2 rst_n = 1'b1;

    // R7: empty matrix on every row
    cur_req = "R7";
    for (int r = 0; r < 8; r++) begin
      do_read(16'h6800 | (16'h7FF & ~(16'h1 << r)), 1'b1, 1'b1, got, v);
      check("R7", "empty direct row", got, 8'h7F);
    end
    for (int k = 0; k < 4; k++) begin
      do_read(16'h68FF | (16'(k) << 8), 1'b1, 1'b1, got, v);
      check("R7", "empty coded row", got, 8'h7F);
    end

    // R2: one key per direct row
    cur_req = "R2";
    for (int r = 0; r < 8; r++) begin
      keys = '0; keys[r][r % 7] = 1'b1;
      do_read(16'h6800 | (16'h7FF & ~(16'h1 << r)), 1'b1, 1'b1, got, v);
      check("R2", "direct row byte", got, 8'h7F & ~(8'h1 << (r % 7)));
      // same key, other row read: not seen
      do_read(16'h6800 | (16'h7FF & ~(16'h1 << ((r + 1) % 8))), 1'b1, 1'b1, got, v);
      check("R2", "other row byte", got, 8'h7F);
    end

    // R3: coded rows 8..11 and unused codes 4..7
    cur_req = "R3";
    keys = '0;
    for (int k = 0; k < 4; k++) keys[8 + k][k + 2] = 1'b1;
    for (int k = 0; k < 8; k++) begin
      do_read(16'h68FF | (16'(k) << 8), 1'b1, 1'b1, got, v);
      check("R3", "coded byte", got, (k < 4) ? (8'h7F & ~(8'h1 << (k + 2))) : 8'h7F);
    end

    // R4: reads outside window, bank off, strobe off
    cur_req = "R4";
    keys = '0; keys[0][0] = 1'b1;
    do_read(16'h7000 | 16'h7FE, 1'b1, 1'b1, got, v);
    check("R4", "above window valid", v, 0);
    do_read(16'h67FE, 1'b1, 1'b1, got, v);
    check("R4", "below window valid", v, 0);
    do_read(16'h6FFE, 1'b0, 1'b1, got, v);
    check("R4", "bank off valid", v, 0);
    do_read(16'h6FFE, 1'b1, 1'b0, got, v);
    check("R4", "no strobe valid", v, 0);
    check("R4", "no strobe data", got, 0);
    do_read(16'h6FFE, 1'b1, 1'b1, got, v);
    check("R4", "window edge valid", v, 1);

    // R5: tape bit and column sampling
    cur_req = "R5";
    tape_in = 1'b1;
    do_read(16'h6FFE, 1'b1, 1'b1, got, v);
    check("R5", "tape high byte", got, 8'hFE);
    tape_in = 1'b0;
    do_read(16'h6FFE, 1'b1, 1'b1, got, v);
    check("R5", "tape low byte", got, 8'h7E);

    // R6: direct rows 0,1 together with coded row 8
    cur_req = "R6";
    keys = '0; keys[0][1] = 1'b1; keys[1][3] = 1'b1; keys[8][6] = 1'b1; keys[9][0] = 1'b1;
    do_read(16'h68FC, 1'b1, 1'b1, got, v);
    check("R6", "wired AND byte", got, 8'h7F & ~8'h4A);
    do_read(16'h6CFC, 1'b1, 1'b1, got, v); // code 4: no coded row
    check("R6", "code 4 with direct", got, 8'h7F & ~8'h0A);
    // back-to-back reads
    @(posedge clk); #2 cpu_addr = 16'h6FFE; io_bank_sel = 1'b1; cpu_rd = 1'b1;
    @(posedge clk); #2 cpu_addr = 16'h69FF;
    @(posedge clk); #2 cpu_rd = 1'b0; io_bank_sel = 1'b0;
    @(negedge clk);
    check("R5", "back-to-back second byte", rd_data, 8'h7E);
    repeat (3) @(posedge clk);
    finish_run();
  end
endmodule